// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock (the VCO-rate signal of a synthesizer loop) by a programmable ratio and emits one comparison pulse `fp_o` per output period. The ratio comes from a dual-modulus prescaler, a 7-bit swallow counter and an 11-bit main counter. At the start of every output period both counters are loaded. The prescaler divides by P+1 for the first A of its own cycles and by P for the remaining N−A cycles, so one output period lasts P·N + A input clocks.

The prescaler pair is chosen by a select input: 128/129 or 64/65. The swallow value, main value and select are held steady on the block's inputs by an upstream register. A new setting is taken only at an output-period boundary, so no period is ever built from two settings. A setting that cannot be realised is rejected. The divider then keeps its previous ratio and raises a sticky error flag.

Top module: `pswal_divider`

## Requirements
- R1: With `psc_sel_i` = 0 the prescaler pair is 128/129 (P = 128). With `psc_sel_i` = 1 it is 64/65 (P = 64). The number of input clocks between successive `fp_o` pulses equals P·N + A.
- R2: The swallow value `swal_i` is 7 bits wide and unsigned. Every value from 0 to 127 is accepted when it is smaller than N. A = 127 with N = 128 gives a period of 64·128 + 127 = 8319 clocks in the 64/65 mode.
- R3: Within one output period the prescaler runs A cycles at P+1 and then N−A cycles at P. The limit case A = N−1 therefore gives P·N + N − 1 clocks.
- R4: `fp_o` is high for exactly one input clock per output period.
- R5: A change of `psc_sel_i`, `swal_i` or `main_i` in the middle of an output period does not alter that period. The new ratio applies from the next period onward.
- R6: At a period boundary, a request with N < 16 or A ≥ N is rejected. The divider keeps the ratio already in use, and `cfg_err_o` goes high in the same clock as the `fp_o` pulse that ends the period.
- R7: `cfg_err_o` stays high after a later valid request. Only `rst_ni` clears it.
- R8: While `rst_ni` is low, `fp_o` and `cfg_err_o` are 0. After release the divider runs the default setting (64/65 mode, N = 16, A = 0). The first `fp_o` pulse is therefore seen 1024 clocks after reset release.
- R9: The lower limits N = 16 and A = 0 are valid settings and give P·16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psc_sel_i | input | 1 | Prescaler pair select: 0 = 128/129, 1 = 64/65 |
| swal_i | input | 7 | Requested swallow count A |
| main_i | input | 11 | Requested main count N |
| fp_o | output | 1 | Divided comparison pulse, one clock wide |
| cfg_err_o | output | 1 | Sticky flag for a rejected request |

## Verification
The bench counts clocks between `fp_o` pulses and compares each count with P·N + A for both prescaler pairs. It puts particular weight on the limit settings A = 0, A = N−1 and A = 127. A swallow counter that stops one cycle early or late would show up there as a period off by one.

Each new setting is applied right after a pulse. The period then in progress must still show the old ratio; a divider that loads settings immediately would produce a mixed period. The settings A = N and N = 15 are then requested. A design without the guard would change ratio or divide wrongly. A design that does not hold the error flag would drop it once a valid setting returns. Reset is pulsed at the end to show that the flag clears.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  parameter int unsigned SWAL_W    = 7;
  parameter int unsigned MAIN_W    = 11;
  parameter int unsigned PSC_SMALL = 64;
  parameter int unsigned PSC_LARGE = 128;
  parameter int unsigned MAIN_MIN  = 16;

  typedef struct packed {
    logic              sel;
    logic [SWAL_W-1:0] swal;
    logic [MAIN_W-1:0] main;
  } pswal_cfg_t;
endpackage

// File: rtl/pswal_cfg_guard.sv
module pswal_cfg_guard
  import pswal_pkg::*;
#(
  parameter int unsigned RST_MAIN = MAIN_MIN,
  parameter int unsigned RST_SWAL = 0,
  parameter bit          RST_SEL  = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  pswal_cfg_t req_i,
  output pswal_cfg_t act_o,
  output pswal_cfg_t nxt_o,
  output logic       err_o
);
  pswal_cfg_t act_q;
  logic       err_q;
  logic       req_ok;

  assign req_ok = (req_i.main >= MAIN_W'(MAIN_MIN)) &&
                  (MAIN_W'(req_i.swal) < req_i.main);
  // counters reload from the setting that will be active next
  assign nxt_o  = req_ok ? req_i : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '{sel: RST_SEL, swal: SWAL_W'(RST_SWAL), main: MAIN_W'(RST_MAIN)};
      err_q <= 1'b0;
    end else if (load_i) begin
      act_q <= nxt_o;
      if (!req_ok) err_q <= 1'b1;
    end
  end

  assign act_o = act_q;
  assign err_o = err_q;

  assert_active_cfg_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.main >= MAIN_W'(MAIN_MIN)) && (MAIN_W'(act_q.swal) < act_q.main));
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_cfg_hold_mid_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_q));
endmodule

// File: rtl/pswal_prescaler.sv
module pswal_prescaler
  import pswal_pkg::*;
#(
  parameter int unsigned SMALL = PSC_SMALL,
  parameter int unsigned LARGE = PSC_LARGE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_small_i,
  input  logic swallow_i,
  output logic tick_o
);
  localparam int unsigned PC_W = $clog2(LARGE + 2);
  localparam logic [PC_W-1:0] SM_LAST = PC_W'(SMALL - 1);
  localparam logic [PC_W-1:0] SM_SWAL = PC_W'(SMALL);
  localparam logic [PC_W-1:0] LG_LAST = PC_W'(LARGE - 1);
  localparam logic [PC_W-1:0] LG_SWAL = PC_W'(LARGE);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last;

  always_comb begin
    if (sel_small_i) last = swallow_i ? SM_SWAL : SM_LAST;
    else             last = swallow_i ? LG_SWAL : LG_LAST;
  end

  assign tick_o = (pc_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (tick_o) pc_q <= '0;
    else             pc_q <= pc_q + 1'b1;
  end

  assert_psc_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= LG_SWAL);
endmodule

// File: rtl/pswal_count_chain.sv
module pswal_count_chain
  import pswal_pkg::*;
#(
  parameter int unsigned RST_MAIN = MAIN_MIN,
  parameter int unsigned RST_SWAL = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [SWAL_W-1:0] swal_ld_i,
  input  logic [MAIN_W-1:0] main_ld_i,
  output logic              swallow_o,
  output logic              wrap_o,
  output logic              fp_o
);
  logic [SWAL_W-1:0] a_q;
  logic [MAIN_W-1:0] n_q;
  logic              fp_q;

  assign wrap_o    = tick_i && (n_q == MAIN_W'(1));
  assign swallow_o = (a_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= SWAL_W'(RST_SWAL);
      n_q  <= MAIN_W'(RST_MAIN);
      fp_q <= 1'b0;
    end else begin
      fp_q <= wrap_o;
      if (wrap_o) begin
        a_q <= swal_ld_i;
        n_q <= main_ld_i;
      end else if (tick_i) begin
        n_q <= n_q - 1'b1;
        if (swallow_o) a_q <= a_q - 1'b1;
      end
    end
  end

  assign fp_o = fp_q;

  assert_swal_below_main_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    MAIN_W'(a_q) < n_q);
  assert_fp_single_clock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_q |=> !fp_q);
  assert_main_nonzero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_q != '0);
endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
  import pswal_pkg::*;
#(
  parameter int unsigned RST_MAIN = MAIN_MIN,
  parameter int unsigned RST_SWAL = 0,
  parameter bit          RST_SEL  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psc_sel_i,
  input  logic [SWAL_W-1:0] swal_i,
  input  logic [MAIN_W-1:0] main_i,
  output logic              fp_o,
  output logic              cfg_err_o
);
  pswal_cfg_t req, act, nxt;
  logic       tick, swallow, wrap;

  assign req = '{sel: psc_sel_i, swal: swal_i, main: main_i};

  pswal_cfg_guard #(.RST_MAIN(RST_MAIN), .RST_SWAL(RST_SWAL), .RST_SEL(RST_SEL)) u_guard (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(wrap),
    .req_i (req),   .act_o (act),    .nxt_o (nxt), .err_o(cfg_err_o)
  );

  pswal_prescaler u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_small_i(act.sel),
    .swallow_i(swallow), .tick_o(tick)
  );

  pswal_count_chain #(.RST_MAIN(RST_MAIN), .RST_SWAL(RST_SWAL)) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .swal_ld_i(nxt.swal), .main_ld_i(nxt.main),
    .swallow_o(swallow), .wrap_o(wrap), .fp_o(fp_o)
  );

  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (!fp_o && !cfg_err_o));
endmodule

// File: tb/pswal_divider_tb.sv
module pswal_divider_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psc_sel_i = 1'b1;
  logic [6:0]  swal_i = '0;
  logic [10:0] main_i = 11'd16;
  logic        fp_o, cfg_err_o;

  int n_chk = 0, n_bad = 0;
  int cur_ratio;
  bit err_exp = 1'b0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pswal_divider dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .psc_sel_i(psc_sel_i),
    .swal_i(swal_i), .main_i(main_i), .fp_o(fp_o), .cfg_err_o(cfg_err_o)
  );

  function automatic int ratio_f(bit sel, int a, int n);
    return (sel ? 64 : 128) * n + a;
  endfunction

  function automatic bit legal_f(int a, int n);
    return (n >= 16) && (a < n);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts negedges up to and including the next fp sample
  task automatic wait_fp(output int cnt);
    cnt = 0;
    forever begin
      @(negedge clk_i);
      cnt++;
      if (cnt == 1) chk(fp_o == 1'b0, "R4 fp width", int'(fp_o), 0);
      if (fp_o) break;
    end
  endtask

  // called right after an fp sample: the running period keeps the old ratio
  task automatic run_cfg(bit sel, int a, int n, string tag);
    int p_old, p_new;
    psc_sel_i = sel;
    swal_i    = 7'(a);
    main_i    = 11'(n);
    wait_fp(p_old);
    chk(p_old == cur_ratio, {"R5 period in flight ", tag}, p_old, cur_ratio);
    if (legal_f(a, n)) cur_ratio = ratio_f(sel, a, n);
    else               err_exp = 1'b1;
    chk(cfg_err_o == err_exp, {"R6/R7 err flag ", tag}, int'(cfg_err_o), int'(err_exp));
    wait_fp(p_new);
    chk(p_new == cur_ratio, {"ratio ", tag}, p_new, cur_ratio);
  endtask

  initial begin
    int p, a, n;
    bit s;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk_i);
    chk(fp_o == 1'b0 && cfg_err_o == 1'b0, "R8 reset outputs", int'({fp_o, cfg_err_o}), 0);
    rst_ni = 1'b1;
    wait_fp(p);
    chk(p == 1024, "R8 first period after reset", p, 1024);
    cur_ratio = 1024;

    run_cfg(1'b1, 0, 16, "R9 min N small pair");
    run_cfg(1'b0, 0, 16, "R1 R9 large pair");
    run_cfg(1'b0, 15, 16, "R3 A=N-1 large pair");
    run_cfg(1'b1, 5, 20, "R1 small pair");
    run_cfg(1'b1, 20, 20, "R6 A=N rejected");
    run_cfg(1'b0, 3, 15, "R6 N=15 rejected");
    run_cfg(1'b1, 127, 128, "R2 A=127 R7 err held");
    run_cfg(1'b1, 9, 17, "R7 err held after valid");

    for (int i = 0; i < 10; i++) begin
      n = 16 + int'($urandom % 16);
      a = int'($urandom % 32);
      s = 1'($urandom % 2);
      run_cfg(s, a, n, "R1 R3 random");
    end

    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(cfg_err_o == 1'b0, "R7 err cleared by reset", int'(cfg_err_o), 0);
    psc_sel_i = 1'b1; swal_i = '0; main_i = 11'd16;
    rst_ni = 1'b1;
    wait_fp(p);
    chk(p == 1024, "R8 period after second reset", p, 1024);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule